// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is the management-bus master that talks to an external PHY. Host logic programs an address register with a 5-bit PHY address and a 5-bit register address. For a write it also loads a 16-bit data register. A pulse on the command strobe then starts one transaction. The engine divides the system clock down to the management clock MDC and shifts a complete frame onto MDIO. The frame is a preamble of ones, the start and operation codes, both addresses and the turnaround, followed by 16 data bits. It ends with a short idle period during which the line is released.

On a read, the master releases the line from the turnaround onwards. It checks the second turnaround bit to find out whether the addressed PHY is answering, and it collects the 16 data bits. A responding PHY's data is written into the same data register that write transactions read from. A silent PHY raises an error flag instead. A busy flag covers the whole transaction, and host writes that arrive during it are dropped. The bidirectional MDIO line is brought out as a separate output value, output enable and input, for an external pad.

Top module: `mdio_master`

## Requirements
- R1: A frame begins with 32 MDC periods of MDIO driven high, followed by the start code 0 then 1 (the first bit on the wire is the first listed).
- R2: The two operation bits are 0,1 when `cmd_write`=1 at the command strobe (write) and 1,0 when `cmd_write`=0 (read).
- R3: After the operation bits, the 5-bit PHY address and then the 5-bit register address from the address register are sent, each most significant bit first.
- R4: On a write, the master drives the turnaround as 1 then 0 and then the 16 bits of the data register, most significant bit first. The data register keeps its value after the write.
- R5: On a read, `mdio_oe` is low for both turnaround bits and all 16 data bits, and MDIO is sampled at rising MDC. If the second turnaround bit reads 0, the 16 sampled bits (first bit = bit 15) are stored in the data register and appear on `data_out`.
- R6: On a read whose second turnaround bit samples 1, `rd_err` is set and the data register keeps its previous value. `rd_err` never rises on a write.
- R7: The 64 frame bits are followed by IDLE_BITS (default 2) MDC periods with `mdio_oe` low. `busy` falls at the last falling MDC edge, and `done` is then set.
- R8: MDC has a period of 2*`half_div` system clocks, and a `half_div` of 0 acts as 1. A transaction keeps `busy` high for exactly (64+IDLE_BITS)*2*`half_div` cycles. MDC is low whenever `busy` is low, and `mdio_o`/`mdio_oe` change only at falling MDC edges, except at the start of a transaction.
- R9: `busy` rises one cycle after the command strobe. While `busy` is high, the command, address and data strobes have no effect on the frame in progress, on `data_out` or on the stored address.
- R10: After reset, `mdc`, `mdio_oe`, `busy`, `done` and `rd_err` are 0 and `data_out` is 0.
- R11: Accepting a new command clears `done` and `rd_err` in the same cycle that `busy` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | MDC half period in system clocks (0 acts as 1) |
| addr_wr | input | 1 | Strobe that loads the address register |
| addr_phy | input | 5 | PHY address value for the address register |
| addr_reg | input | 5 | Register address value for the address register |
| data_wr | input | 1 | Strobe that loads the data register |
| data_in | input | 16 | Write data for the data register |
| cmd_wr | input | 1 | Command strobe that starts a transaction |
| cmd_write | input | 1 | 1 = write transaction, 0 = read transaction |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Last transaction completed |
| rd_err | output | 1 | Last read got no turnaround response |
| data_out | output | 16 | Data register contents |

## Verification
The engine is exercised with writes and with reads, at MDC divisors of 0, 1, 2 and 3. The address corners are all-ones PHY with a zero register and zero PHY with an all-ones register, which separates a swapped or shifted address field from a correct one. A read whose PHY answers is set against one whose PHY stays silent, to show that the turnaround sample alone decides between storing data and raising the error. Two transactions are hit mid-frame with conflicting command, address and data strobes, and the following transaction reuses the address register unchanged, which shows that those strobes were dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int TA_POS     = PRE_BITS + 4 + 2 * ADDR_W;
  localparam int DATA_POS   = TA_POS + 2;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] TA_DRIVE   = 2'b10;

  function automatic logic [FRAME_BITS-1:0] pack_frame(
    input logic              wr,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] ra,
    input logic [DATA_W-1:0] d
  );
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [DATA_W-1:0] body;
    op   = wr ? OP_WRITE : OP_READ;
    ta   = wr ? TA_DRIVE : 2'b11;
    body = wr ? d : '1;
    return {{PRE_BITS{1'b1}}, START_CODE, op, phy, ra, ta, body};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, half_m1;
  logic             mdc_q, mdc_d, tick;

  always_comb begin
    half_m1   = (half_div == '0) ? '0 : half_div - 1'b1;
    tick      = run && (cnt_q == half_m1);
    rise_tick = tick && !mdc_q;
    fall_tick = tick && mdc_q;
  end

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (start) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (run) begin
      if (tick) begin
        cnt_d = '0;
        mdc_d = ~mdc_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

  // R8: the clock can only rise while a transaction is running
  assert_mdc_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_q) |-> $past(run));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int IDLE_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  is_write,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  rise_tick,
  input  logic                  fall_tick,
  input  logic                  mdio_i,
  output logic                  active,
  output logic                  finish,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  no_resp
);
  localparam int TOTAL = FRAME_BITS + IDLE_BITS;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(TA_POS + 1);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);
  localparam logic [IDX_W-1:0] END_IDX  = IDX_W'(FRAME_BITS);

  logic                  act_q, act_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [DATA_W-1:0]     rd_q, rd_d;
  logic                  bad_q, bad_d;

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    rd_d  = rd_q;
    bad_d = bad_q;
    if (start) begin
      act_d = 1'b1;
      idx_d = '0;
      sh_d  = frame_in;
      rd_d  = '0;
      bad_d = 1'b0;
    end else if (act_q) begin
      if (rise_tick && !is_write) begin
        if (idx_q == TA2_IDX) bad_d = mdio_i;
        if (idx_q >= DAT_IDX && idx_q < END_IDX) rd_d = {rd_q[DATA_W-2:0], mdio_i};
      end
      if (fall_tick) begin
        if (idx_q == LAST_IDX) begin
          act_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      sh_q  <= '0;
      rd_q  <= '0;
      bad_q <= 1'b0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      rd_q  <= rd_d;
      bad_q <= bad_d;
    end
  end

  always_comb begin
    active  = act_q;
    finish  = act_q && fall_tick && (idx_q == LAST_IDX);
    mdio_oe = act_q && (idx_q < END_IDX) && (is_write || idx_q < TA_IDX);
    mdio_o  = mdio_oe && sh_q[FRAME_BITS-1];
    rd_data = rd_q;
    no_resp = bad_q;
  end

  // R9: bit position only moves forward while a frame runs (no restart mid-frame)
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q)) |-> (idx_q >= $past(idx_q)));
  // R7: the frame never runs past the end of the idle field
  assert_idx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (idx_q <= LAST_IDX));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int IDLE_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_phy,
  input  logic [ADDR_W-1:0] addr_reg,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              cmd_wr,
  input  logic              cmd_write,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic              done,
  output logic              rd_err,
  output logic [DATA_W-1:0] data_out
);
  logic [ADDR_W-1:0] phy_q, phy_d, ra_q, ra_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              op_q, op_d, done_q, done_d, err_q, err_d;
  logic              active, start, finish, rise_tick, fall_tick, no_resp;
  logic [DATA_W-1:0] rd_data;
  logic [FRAME_BITS-1:0] frame;

  assign start = cmd_wr && !active;
  assign frame = pack_frame(cmd_write, phy_q, ra_q, dat_q);

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start), .run(active),
    .half_div(half_div), .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_shifter #(.IDLE_BITS(IDLE_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(op_q), .frame_in(frame),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .active(active), .finish(finish), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(rd_data), .no_resp(no_resp)
  );

  always_comb begin
    phy_d  = phy_q;
    ra_d   = ra_q;
    dat_d  = dat_q;
    op_d   = op_q;
    done_d = done_q;
    err_d  = err_q;
    if (!active) begin
      if (addr_wr) begin
        phy_d = addr_phy;
        ra_d  = addr_reg;
      end
      if (data_wr) dat_d = data_in;
      if (start) begin
        op_d   = cmd_write;
        done_d = 1'b0;
        err_d  = 1'b0;
      end
    end else if (finish) begin
      done_d = 1'b1;
      if (!op_q) begin
        err_d = no_resp;
        if (!no_resp) dat_d = rd_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_q  <= '0;
      ra_q   <= '0;
      dat_q  <= '0;
      op_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      phy_q  <= phy_d;
      ra_q   <= ra_d;
      dat_q  <= dat_d;
      op_q   <= op_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign busy     = active;
  assign done     = done_q;
  assign rd_err   = err_q;
  assign data_out = dat_q;

  // R8: the management clock rests low between transactions
  assert_mdc_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  // R8: the pad enable moves only at a falling clock or at the start of a frame
  assert_oe_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> ($fell(mdc) || $rose(busy)));
  // R11: a newly accepted command starts with clear status
  assert_status_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!done && !rd_err));
  // R6: the error flag comes only from read transactions
  assert_err_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_err) |-> !op_q);
  // R9: the data register is frozen during a transaction
  assert_data_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(data_out));
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int DIV_W = 8;
  localparam int IDLE  = 2;
  localparam int TOT   = 64 + IDLE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [DIV_W-1:0] half_div = '0;
  logic addr_wr = 0, data_wr = 0, cmd_wr = 0, cmd_write = 0, mdio_i = 1'b1;
  logic [4:0] addr_phy = '0, addr_reg = '0;
  logic [15:0] data_in = '0;
  logic mdc, mdio_o, mdio_oe, busy, done, rd_err;
  logic [15:0] data_out;

  mdio_master #(.DIV_W(DIV_W), .IDLE_BITS(IDLE)) u0 (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .addr_wr(addr_wr),
    .addr_phy(addr_phy), .addr_reg(addr_reg), .data_wr(data_wr), .data_in(data_in),
    .cmd_wr(cmd_wr), .cmd_write(cmd_write), .mdio_i(mdio_i), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy), .done(done),
    .rd_err(rd_err), .data_out(data_out)
  );

  int tests = 0, fails = 0, lk_tests = 0, lk_fails = 0;

  function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r,
            (wr ? 2'b10 : 2'b11), (wr ? d : 16'hFFFF)};
  endfunction

  // ---------------- PHY behaviour: drives the bit that follows each falling MDC
  logic        phy_ack = 1'b1;
  logic [15:0] phy_val = '0;
  int          fcnt = 0;
  always @(negedge mdc) if (rst_n) begin
    fcnt = (fcnt + 1 == TOT) ? 0 : fcnt + 1;
    if (fcnt == 47)                  mdio_i = !phy_ack;
    else if (fcnt >= 48 && fcnt < 64) mdio_i = phy_val[63 - fcnt];
    else                             mdio_i = 1'b1;
  end

  // ---------------- capture of the line at every rising MDC
  logic cap_o [TOT];
  logic cap_oe[TOT];
  int   rcnt = 0;
  always @(posedge mdc) if (rst_n) begin
    cap_o[rcnt]  = mdio_o;
    cap_oe[rcnt] = mdio_oe;
    rcnt = (rcnt + 1 == TOT) ? 0 : rcnt + 1;
  end

  // ---------------- cycle reference model
  logic m_act, m_mdc, m_wr, m_bad, m_done, m_err, m_oe, m_o;
  int   m_cnt, m_idx, hv;
  logic [63:0] m_frame;
  logic [15:0] m_rd, m_data;
  logic [4:0]  m_phy, m_reg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_mdc = 0; m_wr = 0; m_bad = 0; m_done = 0; m_err = 0;
      m_cnt = 0; m_idx = 0; m_frame = '0; m_rd = '0; m_data = '0;
      m_phy = '0; m_reg = '0;
    end else begin
      hv = (half_div == 0) ? 1 : int'(half_div);
      if (!m_act) begin
        if (cmd_wr) begin
          m_act = 1; m_cnt = 0; m_mdc = 0; m_idx = 0; m_wr = cmd_write;
          m_frame = exp_frame(cmd_write, m_phy, m_reg, m_data);
          m_rd = '0; m_bad = 0; m_done = 0; m_err = 0;
        end
        if (addr_wr) begin m_phy = addr_phy; m_reg = addr_reg; end
        if (data_wr) m_data = data_in;
      end else if (m_cnt == hv - 1) begin
        m_cnt = 0;
        if (!m_mdc) begin
          m_mdc = 1;
          if (!m_wr) begin
            if (m_idx == 47) m_bad = mdio_i;
            if (m_idx >= 48 && m_idx < 64) m_rd = {m_rd[14:0], mdio_i};
          end
        end else begin
          m_mdc = 0;
          if (m_idx == TOT - 1) begin
            m_act = 0; m_done = 1;
            if (!m_wr) begin
              m_err = m_bad;
              if (!m_bad) m_data = m_rd;
            end
          end else m_idx++;
        end
      end else m_cnt++;
    end
    m_oe = m_act && (m_idx < 64) && (m_wr || m_idx < 46);
    m_o  = m_oe && m_frame[63 - m_idx];
  end

  always @(negedge clk) if (rst_n) begin
    lk_tests++;
    if (mdc !== m_mdc || busy !== m_act || mdio_oe !== m_oe || (m_oe && mdio_o !== m_o) ||
        data_out !== m_data || done !== m_done || rd_err !== m_err) begin
      lk_fails++;
      $display("FAIL lockstep R8 R9 actual mdc%b busy%b oe%b o%b done%b err%b d%h expected mdc%b busy%b oe%b o%b done%b err%b d%h",
               mdc, busy, mdio_oe, mdio_o, done, rd_err, data_out,
               m_mdc, m_act, m_oe, m_o, m_done, m_err, m_data);
    end
  end

  // ---------------- directed checks
  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [4:0]  cur_phy = '0, cur_reg = '0;
  logic [15:0] exp_data = '0;

  task automatic run_txn(input logic wr, input logic set_addr, input logic [4:0] p,
                         input logic [4:0] r, input logic [15:0] d, input logic ack,
                         input logic [15:0] pval, input int h, input logic poke);
    int cyc;
    logic [63:0] cv, cm, ef;
    @(negedge clk);
    half_div = DIV_W'(h);
    phy_ack  = ack;
    phy_val  = pval;
    if (set_addr) begin addr_wr = 1; addr_phy = p; addr_reg = r; cur_phy = p; cur_reg = r; end
    if (wr) begin data_wr = 1; data_in = d; exp_data = d; end
    @(negedge clk);
    addr_wr = 0; data_wr = 0;
    cmd_wr = 1; cmd_write = wr;
    @(negedge clk);
    cmd_wr = 0;
    check("R9 busy after strobe", {63'd0, busy}, 64'd1);
    check("R11 status cleared at start", {62'd0, done, rd_err}, 64'd0);
    cyc = 1;
    while (busy) begin
      if (poke && cyc == 20) begin
        cmd_wr = 1; cmd_write = !wr; addr_wr = 1; addr_phy = ~p; addr_reg = ~r;
        data_wr = 1; data_in = 16'hDEAD;
      end else begin
        cmd_wr = 0; addr_wr = 0; data_wr = 0;
      end
      @(negedge clk);
      if (busy) cyc++;
    end
    cmd_wr = 0; addr_wr = 0; data_wr = 0;
    ef = exp_frame(wr, cur_phy, cur_reg, exp_data);
    for (int k = 0; k < 64; k++) begin
      cv[63 - k] = cap_oe[k] ? cap_o[k] : 1'b0;
      cm[63 - k] = cap_oe[k];
    end
    check("R1 preamble and start", {30'd0, cv[63:30]}, {30'd0, ef[63:30]});
    check("R2 opcode", {62'd0, cv[29:28]}, {62'd0, (wr ? 2'b01 : 2'b10)});
    check(poke ? "R3 addresses (R9 strobes ignored)" : "R3 addresses",
          {54'd0, cv[27:18]}, {54'd0, cur_phy, cur_reg});
    if (wr) begin
      check("R4 turnaround and data", {46'd0, cv[17:0]}, {46'd0, 2'b10, exp_data});
      check("R4 line driven whole frame", cm, '1);
    end else begin
      check("R5 line released from turnaround", cm, {{46{1'b1}}, 18'd0});
    end
    check("R7 idle released", {62'd0, cap_oe[64], cap_oe[65]}, 64'd0);
    check("R8 busy length", 64'(cyc), 64'(TOT * 2 * ((h == 0) ? 1 : h)));
    check("R7 done after idle", {63'd0, done}, 64'd1);
    if (!wr && ack) exp_data = pval;
    check(wr ? "R4 data register kept" : (ack ? "R5 read data stored" : "R6 data kept on no response"),
          {48'd0, data_out}, {48'd0, exp_data});
    check(ack || wr ? "R6 no error" : "R6 error on no response",
          {63'd0, rd_err}, {63'd0, (!wr && !ack)});
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests + lk_tests + 1, fails + lk_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {58'd0, mdc, mdio_oe, busy, done, rd_err, 1'b0}, 64'd0);
    check("R10 reset data", {48'd0, data_out}, 64'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R10 idle after release", {61'd0, mdc, busy, mdio_oe}, 64'd0);
    run_txn(1, 1, 5'd5,  5'h11, 16'hA5C3, 1, 16'h0000, 2, 0);
    run_txn(0, 1, 5'd31, 5'd0,  16'h0000, 1, 16'h1234, 1, 0);
    run_txn(0, 1, 5'd0,  5'd31, 16'h0000, 0, 16'hBEEF, 3, 0);
    run_txn(0, 1, 5'd10, 5'd3,  16'h0000, 1, 16'h8001, 0, 1);
    run_txn(1, 0, 5'd0,  5'd0,  16'h0F0F, 1, 16'h0000, 2, 1);
    repeat (5) @(negedge clk);
    check("R8 clock low when idle", {62'd0, mdc, busy}, 64'd0);
    $display("  [TB] %0d tests run, %0d failed", tests + lk_tests, fails + lk_fails);
    $finish;
  end
endmodule